// File: doc/BRIEF.md
# Programmable Up-Counting Timer

The block is a single 28-bit up-counter with a clock prescaler, a programmable end value and an interrupt flag, all reached through a small word-addressed register bus. Software stops the timer, loads the count (normally zero), programs the end value and then writes the control word with the enable bit, a mode bit and a clock divisor. From then on the counter advances by one on every prescaler tick.

When the count sits at the programmed end value, or at the 28-bit all-ones value, the next tick returns it to zero and raises a pending flag. In one-shot mode the enable is then dropped and the counter rests at zero. In periodic mode it keeps counting, so it serves as a tick source. The interrupt output is driven high while the pending flag and its enable bit are both set. Software clears the flag by writing a one to it.

Top module: `upcount_timer`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: Words sit at byte offsets 0x0 (end value, bits [27:0]), 0x4 (count, bits [27:0]), 0x8 (control: enable bit 28, mode bit 24, divisor bits [15:0]) and 0xC (interrupt: enable bit 20, pending bit 16). All other bits read as zero. Read data appears on `bus_rdata` one clock after the read is presented.
- R3: The count rises by exactly one per prescaler tick while enabled. It holds its value while disabled. Writing the control word never produces a tick on that same edge.
- R4: With divisor N >= 2 the count steps once every N clocks, the first step landing N clocks after the control write. A divisor of 0 or 1 steps on every clock.
- R5: With a non-zero end value E, a tick taken while the count equals E returns the count to zero and sets the pending flag.
- R6: An end value of zero disables the end marker, so the count wraps only from 0x0FFFFFFF to zero, which also sets the pending flag.
- R7: In one-shot mode (mode bit 0) a wrap clears the control enable bit and the count stays at zero.
- R8: In periodic mode (mode bit 1) the counter keeps running after a wrap, so the count repeats with period E+1 ticks.
- R9: Writing the count register loads the written value, taking priority over a tick on the same edge.
- R10: Writing 1 to pending bit 16 clears the flag. Writing 0 there leaves it unchanged. A wrap on the same edge as the clearing write leaves the flag set.
- R11: `irq_o` is high exactly when the pending flag and the interrupt enable are both set. The pending flag sets even while the interrupt enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte address; bits [3:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A write takes effect on the clock edge that samples it. A read returns the state held just before the following edge, so the bench counts edges from the control write to get each expected count. The formula is floor(m/N) for m idle cycles after the write with divisor N, and m mod (E+1) for a periodic run with end value E. The bench applies the same rule to predict when the pending flag and the one-shot enable clear become visible.

`irq_o` is registered on the same edge as the flag it follows, so it is sampled on the falling edge right after the causing write. All stimulus moves on falling edges, so every sample is taken half a period away from the edge it depends on.

// File: rtl/ut_pkg.sv
package ut_pkg;
  localparam int CTL_EN_BIT   = 28;
  localparam int CTL_MODE_BIT = 24;
  localparam int IRQ_EN_BIT   = 20;
  localparam int IRQ_PEND_BIT = 16;

  typedef enum logic [1:0] {
    WORD_END = 2'd0,
    WORD_CNT = 2'd1,
    WORD_CTL = 2'd2,
    WORD_IRQ = 2'd3
  } word_e;

  typedef enum logic {
    MODE_ONESHOT  = 1'b0,
    MODE_PERIODIC = 1'b1
  } mode_e;
endpackage

// File: rtl/ut_prescale.sv
module ut_prescale #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] phase_q;
  logic             single;

  assign single = (div <= DIV_W'(1));
  assign tick   = run && !restart && (single || (phase_q >= div - DIV_W'(1)));

  always_ff @(posedge clk) begin
    if (rst || !run || restart) phase_q <= '0;
    else if (tick)              phase_q <= '0;
    else                        phase_q <= phase_q + DIV_W'(1);
  end

  // R4
  gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !single && !restart) |=> !tick);
endmodule

// File: rtl/ut_count.sv
module ut_count #(
  parameter int CNT_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] end_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_limit;

  assign at_limit = ((end_val != '0) && (cnt_q == end_val)) || (cnt_q == {CNT_W{1'b1}});
  assign wrap     = tick && !load && at_limit;
  assign cnt      = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (tick) cnt_q <= at_limit ? '0 : cnt_q + CNT_W'(1);
  end

  // R3
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load) |=> (cnt_q == '0) || (cnt_q == $past(cnt_q) + CNT_W'(1)));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cnt_q));
  // R9
  load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/ut_irqflag.sv
module ut_irqflag (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic wr_ie,
  input  logic wr_clr,
  input  logic set,
  output logic pend,
  output logic ie,
  output logic irq
);
  logic pend_q, ie_q, irq_q, pend_d, ie_d;

  always_comb begin
    pend_d = pend_q;
    ie_d   = ie_q;
    if (wr) begin
      ie_d = wr_ie;
      if (wr_clr) pend_d = 1'b0;
    end
    if (set) pend_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      ie_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ie_q   <= ie_d;
      irq_q  <= pend_d && ie_d;
    end
  end

  assign pend = pend_q;
  assign ie   = ie_q;
  assign irq  = irq_q;

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set |=> pend_q);
  // R11
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == (pend_q && ie_q));
endmodule

// File: rtl/upcount_timer.sv
module upcount_timer #(
  parameter int CNT_W  = 28,
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  import ut_pkg::*;

  localparam int PAD_W = DATA_W - CNT_W;

  word_e            word;
  logic             wr_end, wr_cnt, wr_ctl, wr_irq, rd_any;
  logic             run_q;
  mode_e            mode_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] end_q;
  logic [CNT_W-1:0] cnt;
  logic             tick, wrap, pend, ie;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  assign word   = word_e'(bus_addr[3:2]);
  assign wr_end = bus_sel && bus_we && (word == WORD_END);
  assign wr_cnt = bus_sel && bus_we && (word == WORD_CNT);
  assign wr_ctl = bus_sel && bus_we && (word == WORD_CTL);
  assign wr_irq = bus_sel && bus_we && (word == WORD_IRQ);
  assign rd_any = bus_sel && !bus_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      mode_q <= MODE_ONESHOT;
      div_q  <= '0;
    end else if (wr_ctl) begin
      run_q  <= bus_wdata[CTL_EN_BIT];
      mode_q <= mode_e'(bus_wdata[CTL_MODE_BIT]);
      div_q  <= bus_wdata[DIV_W-1:0];
    end else if (wrap && (mode_q == MODE_ONESHOT)) begin
      run_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         end_q <= '0;
    else if (wr_end) end_q <= bus_wdata[CNT_W-1:0];
  end

  ut_prescale #(.DIV_W(DIV_W)) u_prescale (
    .clk     (clk),
    .rst     (rst),
    .run     (run_q),
    .restart (wr_ctl),
    .div     (div_q),
    .tick    (tick)
  );

  ut_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .load     (wr_cnt),
    .load_val (bus_wdata[CNT_W-1:0]),
    .end_val  (end_q),
    .cnt      (cnt),
    .wrap     (wrap)
  );

  ut_irqflag u_irqflag (
    .clk    (clk),
    .rst    (rst),
    .wr     (wr_irq),
    .wr_ie  (bus_wdata[IRQ_EN_BIT]),
    .wr_clr (bus_wdata[IRQ_PEND_BIT]),
    .set    (wrap),
    .pend   (pend),
    .ie     (ie),
    .irq    (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    unique case (word)
      WORD_END: rd_mux = {{PAD_W{1'b0}}, end_q};
      WORD_CNT: rd_mux = {{PAD_W{1'b0}}, cnt};
      WORD_CTL: begin
        rd_mux[CTL_EN_BIT]   = run_q;
        rd_mux[CTL_MODE_BIT] = mode_q;
        rd_mux[DIV_W-1:0]    = div_q;
      end
      WORD_IRQ: begin
        rd_mux[IRQ_EN_BIT]   = ie;
        rd_mux[IRQ_PEND_BIT] = pend;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (rd_any) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  // R7
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap && (mode_q == MODE_ONESHOT) && !wr_ctl) |=> !run_q);
  // R8
  periodic_run_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap && (mode_q == MODE_PERIODIC) && !wr_ctl) |=> run_q);
  // R5
  wrap_pend_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (pend && (cnt == '0)));
endmodule

// File: tb/upcount_timer_bench.sv
module upcount_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [3:0] A_END = 4'h0, A_CNT = 4'h4, A_CTL = 4'h8, A_IRQ = 4'hC;
  localparam logic [31:0] EN = 32'h1000_0000, PER = 32'h0100_0000;
  localparam logic [31:0] PEND = 32'h0001_0000, IE = 32'h0010_0000;

  always #5 clk = ~clk;

  upcount_timer u_upcount_timer (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet();
    wr(A_CTL, 32'h0);
    wr(A_IRQ, PEND);
    wr(A_CNT, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    rd(A_END, v); chk("R1 end", v, 0);
    rd(A_CNT, v); chk("R1 cnt", v, 0);
    rd(A_CTL, v); chk("R1 ctl", v, 0);
    rd(A_IRQ, v); chk("R1 irq reg", v, 0);
    chk("R1 irq_o", {31'b0, irq_o}, 0);

    // R2 field placement and zero padding
    wr(A_END, 32'hFFFF_FFFF); rd(A_END, v); chk("R2 end", v, 32'h0FFF_FFFF);
    wr(A_CTL, 32'hFFFF_FFFF); rd(A_CTL, v); chk("R2 ctl", v, 32'h1100_FFFF);
    wr(A_CTL, 32'h0);
    wr(A_IRQ, 32'hFFFF_FFFF); rd(A_IRQ, v); chk("R2 irq", v, IE);
    wr(A_IRQ, 32'h0);
    wr(A_CNT, 32'hF123_4567); rd(A_CNT, v); chk("R2 cnt", v, 32'h0123_4567);

    // R4 prescaler sweep: count = floor(m/N)
    for (int di = 0; di < 5; di++) begin
      int dv;
      dv = (di == 4) ? 5 : di;
      for (int m = 0; m < 13; m++) begin
        quiet();
        wr(A_END, 32'h0);
        wr(A_CTL, EN | PER | dv);
        idle(m);
        rd(A_CNT, v);
        chk($sformatf("R4 div=%0d m=%0d", dv, m), v, m / ((dv <= 1) ? 1 : dv));
      end
    end

    // R5 R8 periodic wrap at end value
    for (int e = 1; e < 5; e++) begin
      for (int m = 0; m < 12; m++) begin
        quiet();
        wr(A_END, e);
        wr(A_CTL, EN | PER | 1);
        idle(m);
        rd(A_CNT, v);
        chk($sformatf("R8 e=%0d m=%0d", e, m), v, m % (e + 1));
        rd(A_IRQ, v);
        chk($sformatf("R5 pend e=%0d m=%0d", e, m), v, (m >= e) ? PEND : 0);
      end
    end

    // R7 one-shot stops after wrap
    for (int m = 0; m < 9; m++) begin
      quiet();
      wr(A_END, 3);
      wr(A_CTL, EN | 1);
      idle(m);
      rd(A_CNT, v);
      chk($sformatf("R7 cnt m=%0d", m), v, (m <= 3) ? m : 0);
      rd(A_CTL, v);
      chk($sformatf("R7 ctl m=%0d", m), v, (m >= 3) ? 32'h1 : (EN | 1));
    end

    // R6 end value zero wraps only at all-ones
    for (int m = 0; m < 6; m++) begin
      quiet();
      wr(A_END, 0);
      wr(A_CNT, 32'h0FFF_FFFD);
      wr(A_CTL, EN | PER | 1);
      idle(m);
      rd(A_CNT, v);
      chk($sformatf("R6 m=%0d", m), v, (32'h0FFF_FFFD + m) & 32'h0FFF_FFFF);
      rd(A_IRQ, v);
      chk($sformatf("R6 pend m=%0d", m), v, (m >= 2) ? PEND : 0);
    end

    // R9 live load while running
    quiet();
    wr(A_END, 0);
    wr(A_CTL, EN | PER | 1);
    idle(5);
    wr(A_CNT, 100);
    rd(A_CNT, v); chk("R9 load", v, 100);
    idle(2);
    rd(A_CNT, v); chk("R9 resume", v, 103);

    // R3 hold when disabled; no tick on control write edge
    quiet();
    wr(A_CTL, EN | PER | 1);
    idle(4);
    wr(A_CTL, 0);
    rd(A_CNT, v); chk("R3 stop value", v, 4);
    idle(5);
    rd(A_CNT, v); chk("R3 hold", v, 4);

    // R10 set wins over simultaneous clear
    quiet();
    wr(A_END, 3);
    wr(A_CTL, EN | PER | 1);
    idle(3);
    wr(A_IRQ, IE | PEND);
    chk("R10 irq_o after race", {31'b0, irq_o}, 1);
    rd(A_IRQ, v); chk("R10 set wins", v, IE | PEND);
    wr(A_CTL, 0);
    wr(A_IRQ, PEND);
    chk("R10 irq_o cleared", {31'b0, irq_o}, 0);
    rd(A_IRQ, v); chk("R10 w1c", v, 0);

    // R11 pending sets while disabled; irq follows enable
    quiet();
    wr(A_IRQ, 0);
    wr(A_END, 1);
    wr(A_CTL, EN | PER | 1);
    idle(4);
    wr(A_CTL, 0);
    chk("R11 masked irq_o", {31'b0, irq_o}, 0);
    rd(A_IRQ, v); chk("R11 pend while masked", v, PEND);
    wr(A_IRQ, IE);
    chk("R11 irq_o unmasked", {31'b0, irq_o}, 1);
    rd(A_IRQ, v); chk("R10 write 0 keeps pend", v, IE | PEND);
    wr(A_IRQ, IE | PEND);
    chk("R11 irq_o after clear", {31'b0, irq_o}, 0);
    rd(A_IRQ, v); chk("R10 clear keeps enable", v, IE);

    finish_run();
  end
endmodule